// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block forms the unsigned product of two operands with a single adder that is reused over many clock cycles. A small controller steps the datapath through load, bit test, conditional add and shift. Each of these steps takes one clock. Once the last multiplier bit has been handled, the double-width result stays on the product output and the idle flag returns high.

A user raises `start` for a cycle while `stop` is high. The operands must stay valid through the following clock edge, which is when they are loaded. The user then waits for `stop` to rise again and reads `product`. The run time depends on the data, because an add step is spent only on multiplier bits that are 1.

Top module: `seq_mult`

## Requirements
- R1: While `rst_n` is low, and immediately after it falls (asynchronously), `stop` is 1 and `product` is 0.
- R2: When `start` is 1 at a rising edge and `stop` is 1, `stop` is 0 from that edge on.
- R3: The operands are captured at the edge that follows the accepted `start` edge. The accumulator and carry are cleared at that same edge, so operand changes after it have no effect on the result.
- R4: When `stop` returns high, `product` equals the full 2W-bit unsigned product of the captured operands (upper half in the accumulator, lower half in the multiplier register).
- R5: After an accepted start, `stop` stays 0 for exactly 1 + 2·W + (number of 1 bits in the captured multiplier) cycles, then returns to 1. An add step occurs only when the tested multiplier bit is 1.
- R6: `start` has no effect while `stop` is 0: operands presented with such a pulse are never used and the running result is unchanged.
- R7: While `stop` is 1 and `start` is 0, `product` holds its value and `stop` stays 1.
- R8: The carry out of each add is kept and shifted into the accumulator, so all-ones operands yield (2^W−1)^2 without loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | W | Multiplicand, sampled at the load edge |
| mplier | input | W | Multiplier, sampled at the load edge |
| product | output | 2W | Accumulator (upper) and multiplier register (lower) |
| stop | output | 1 | High when idle and the result is valid |

## Verification
Operand pairs of zero, one and all-ones show whether add steps are skipped or taken and whether the carry survives. Single-bit multipliers such as 128 and 1 show whether the shift count and alignment are right. Random pairs spread the run length across popcounts, so a cycle-exact `stop` model catches any extra or missing add step. A mid-run start pulse with different operands, a start held high across completion (back-to-back runs) and a reset in mid-run separate the ignore, restart and asynchronous-clear behaviour.

// File: rtl/mult_pkg.sv
package mult_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'b000,
    ST_INIT  = 3'b001,
    ST_TEST  = 3'b010,
    ST_ADD   = 3'b011,
    ST_SHIFT = 3'b100
  } mstate_e;
endpackage

// File: rtl/mult_ctrl.sv
module mult_ctrl
  import mult_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic lsb,
  output logic do_load,
  output logic do_add,
  output logic do_shift,
  output logic stop
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mstate_e st, st_nx;
  logic [CW-1:0] cnt;
  logic last;

  assign last = (cnt == LAST);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (start) st_nx = ST_INIT;
      ST_INIT:  st_nx = ST_TEST;
      ST_TEST:  st_nx = lsb ? ST_ADD : ST_SHIFT;
      ST_ADD:   st_nx = ST_SHIFT;
      ST_SHIFT: st_nx = last ? ST_IDLE : ST_TEST;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st <= st_nx;
      if (st == ST_SHIFT) cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  assign stop     = (st == ST_IDLE);
  assign do_load  = (st == ST_INIT);
  assign do_add   = (st == ST_ADD);
  assign do_shift = (st == ST_SHIFT);
endmodule

// File: rtl/mult_dpath.sv
module mult_dpath #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           do_load,
  input  logic           do_add,
  input  logic           do_shift,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           lsb,
  output logic [2*W-1:0] product
);
  localparam int CH = 2 * W + 1;

  function automatic logic [W:0] acc_plus(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [CH-1:0] chain_right(input logic [CH-1:0] c);
    return {1'b0, c[CH-1:1]};
  endfunction

  logic [W-1:0] ra, acc, rb;
  logic         cy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra  <= '0;
      acc <= '0;
      rb  <= '0;
      cy  <= 1'b0;
    end else if (do_load) begin
      ra  <= mcand;
      rb  <= mplier;
      acc <= '0;
      cy  <= 1'b0;
    end else if (do_add) begin
      {cy, acc} <= acc_plus(acc, ra);
    end else if (do_shift) begin
      {cy, acc, rb} <= chain_right({cy, acc, rb});
    end
  end

  assign lsb     = rb[0];
  assign product = {acc, rb};
endmodule

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] product,
  output logic           stop
);
  logic do_load, do_add, do_shift, lsb;

  mult_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .lsb(lsb),
    .do_load(do_load), .do_add(do_add), .do_shift(do_shift), .stop(stop)
  );

  mult_dpath #(.W(W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .do_load(do_load), .do_add(do_add),
    .do_shift(do_shift), .mcand(mcand), .mplier(mplier),
    .lsb(lsb), .product(product)
  );
endmodule

// File: rtl/seq_mult_chk.sv
module seq_mult_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           stop,
  input logic           do_load,
  input logic           do_add,
  input logic           do_shift,
  input logic           lsb,
  input logic [2*W-1:0] product
);
  int shifts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shifts <= W;
    else if (do_load) shifts <= 0;
    else if (do_shift) shifts <= shifts + 1;
  end

  // R2: accepted start leaves idle
  a_r2_start_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && start) |=> !stop);

  // R3: load is followed by a bit test, never an add or shift
  a_r3_load_then_test: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> (!do_add && !do_shift && !stop));

  // R5: add only on a set bit, and always followed by a shift
  a_r5_add_on_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    do_add |-> lsb);

  a_r5_add_then_shift: assert property (@(posedge clk) disable iff (!rst_n)
    do_add |=> do_shift);

  // R5: exactly W shifts between load and return to idle
  a_r5_w_shifts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop) |-> (shifts == W));

  // R7: idle holds the result
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> (stop && $stable(product)));
endmodule

bind seq_mult seq_mult_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
  .do_load(do_load), .do_add(do_add), .do_shift(do_shift),
  .lsb(lsb), .product(product)
);

// File: tb/seq_mult_test.sv
module seq_mult_test;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic [2*W-1:0] product;
  logic           stop;

  int    nchk = 0;
  int    nerr = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  seq_mult #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
    .mplier(mplier), .product(product), .stop(stop)
  );

  always #4 clk = ~clk;

  function automatic int ones(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) if (v[i]) n++;
    return n;
  endfunction

  // behavioural reference: remaining busy cycles and expected result
  int          busy = 0;
  bit          pend = 1'b0;
  longint      expv = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy = 0; pend = 1'b0; expv = 0;
    end else if (pend) begin
      expv = longint'(mcand) * longint'(mplier);
      busy = 2 * W + ones(mplier);
      pend = 1'b0;
    end else if (busy > 0) begin
      busy = busy - 1;
    end else if (start) begin
      busy = 1;
      pend = 1'b1;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check((busy == 0) ? cur_req : "R5", longint'(stop), (busy == 0) ? 1 : 0);
      if (busy == 0) check(cur_req, longint'(product), expv);
    end
  end

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    mcand = ~a; mplier = ~b;   // R3: changes after the load edge are harmless
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; mcand = 8'h5a; mplier = 8'hc3;   // R6
      @(negedge clk);
      start = 1'b0;
    end
    while (busy != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #3;
    check("R1", longint'(stop), 1);
    check("R1", longint'(product), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R4";
    run(8'd0, 8'd0, 0);
    run(8'd1, 8'd1, 0);
    run(8'd0, 8'd255, 0);
    run(8'd255, 8'd0, 0);
    run(8'd1, 8'd255, 0);
    run(8'd255, 8'd1, 0);
    run(8'd3, 8'd128, 0);
    run(8'd200, 8'd2, 0);

    cur_req = "R8";
    run(8'd255, 8'd255, 0);
    run(8'd254, 8'd255, 0);

    cur_req = "R7";
    repeat (10) @(negedge clk);

    cur_req = "R6";
    run(8'd17, 8'd29, 1);
    run(8'd255, 8'd170, 1);

    cur_req = "R3";
    for (int i = 0; i < 30; i++) run(W'($urandom), W'($urandom), 0);

    // R2: start held high across completion restarts at once
    cur_req = "R2";
    @(negedge clk);
    mcand = 8'd77; mplier = 8'd91; start = 1'b1;
    repeat (2) @(negedge clk);
    check("R2", longint'(stop), 0);
    while (busy != 0) @(negedge clk);
    mcand = 8'd9; mplier = 8'd250;
    repeat (2) @(negedge clk);
    start = 1'b0;
    while (busy != 0) @(negedge clk);
    @(negedge clk);

    // R1: asynchronous reset in the middle of a run
    cur_req = "R4";
    @(negedge clk);
    mcand = 8'd99; mplier = 8'd99; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check("R1", longint'(stop), 1);
    check("R1", longint'(product), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    repeat (2) @(negedge clk);
    cur_req = "R4";
    run(8'd99, 8'd99, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule